// File: doc/BRIEF.md
# Byte-Synchronous Serial Transmitter

This block serialises characters onto a single transmit line, one bit for each bit-clock enable, with no start or stop bits. A producer hands characters over a valid/ready port into a one-character holding buffer. The shift register takes the next character from that buffer at each frame boundary. A data character can carry an optional parity bit. A 16-bit check value is accumulated over the data bits of each character, using one of two polynomials.

Whenever the buffer is empty at a frame boundary, the line is filled with idle sync patterns. A sync pattern is 8 or 16 bits wide. When the check-append option is on, the 16-bit check value is sent once before the idle patterns resume. A break control forces the line low at once. The break also discards the buffer, the shift register and the check state.

The load port follows valid/ready rules. The producer holds `in_valid` and `in_data` steady until it sees `in_ready` high at a rising edge. `in_ready` is high only while the buffer is empty and no break is applied. A producer that presents data while `in_ready` is low is back-pressured, and its data waits at the port.

Top module: `bsync_tx`

## Requirements
- R1: After reset, `txd` is 1, `in_ready` and `buf_empty` are 1 and `irq` is 0. While `tx_en` or `cts_en` is 0 and `brk` is 0, `txd` stays 1, no character leaves the buffer, and the shifter and check state are cleared.
- R2: A character is accepted at a rising edge where `in_valid` and `in_ready` are both 1. The buffer then reads full (`buf_empty` 0, `in_ready` 0) until the shifter takes the character.
- R3: Each character is sent least significant bit first. Its data length is 5, 6, 7 or 8 bits for `len_sel` values 0, 1, 2 and 3, and only the low bits of `in_data` are sent.
- R4: With `par_en` at 1, one parity bit follows the data bits of each buffered character. With `par_odd` at 0 it makes the count of ones in data plus parity even; with `par_odd` at 1 it makes that count odd. Sync and check frames never carry parity.
- R5: At a frame boundary where the buffer is empty and no check value is owed, the block sends a sync frame, and it repeats sync frames while this holds. With `sync16` at 0 the frame is the 8 bits of `sync_lo`. With `sync16` at 1 it is `sync_lo` followed by `sync_hi`. Each byte is sent LSB first.
- R6: The check value starts at zero and is updated with the data bits only, not with parity, taking the bits in the order they are sent. Each bit is combined as fb = bit XOR crc[15], then crc = (crc << 1) XOR (fb ? P : 0). P is 16'h8005 for `crc_sel` 0 and 16'h1021 for `crc_sel` 1. The value returns to zero after it has been sent.
- R7: If `crc_append` is 1 when a data character is taken, then at the next frame boundary with an empty buffer the 16-bit check value is sent, most significant bit first. Sync frames follow it.
- R8: While `brk` is 1, `txd` is 0 in the same cycle, whether or not the transmitter is enabled. `txd` returns to 1 once `brk` is cleared.
- R9: `brk` discards the buffered character, the shifter contents and any owed check value, and holds `in_ready` at 0. After release, the first frame sent is a sync frame.
- R10: When the shifter takes a character, `buf_empty` rises. `irq` is 1 from then until the next accepted character, but only while `tx_int_en` is 1.
- R11: `txd` advances by exactly one bit on each rising edge where `bit_en` is 1, and it holds its value on edges where `bit_en` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_en | input | 1 | Transmitter enable |
| cts_en | input | 1 | Clear-to-send enable; transmission pauses when 0 |
| brk | input | 1 | Send break: forces line low, discards pending data |
| tx_int_en | input | 1 | Buffer-empty interrupt enable |
| len_sel | input | 2 | Data length code, 0..3 means 5..8 bits |
| par_en | input | 1 | Append parity to data characters |
| par_odd | input | 1 | 1 selects odd parity, 0 even |
| crc_sel | input | 1 | 0 selects 16'h8005, 1 selects 16'h1021 |
| crc_append | input | 1 | Send check value when data runs out |
| sync16 | input | 1 | 1 selects a 16-bit sync frame |
| sync_lo | input | 8 | First sync byte |
| sync_hi | input | 8 | Second sync byte (16-bit mode) |
| bit_en | input | 1 | Bit-clock enable, one bit per asserted cycle |
| in_valid | input | 1 | Load port valid |
| in_data | input | 8 | Load port character |
| in_ready | output | 1 | Load port ready (buffer empty, no break) |
| txd | output | 1 | Serial transmit line |
| buf_empty | output | 1 | Holding buffer empty |
| irq | output | 1 | Buffer-empty interrupt |

## Verification
The hardest stream to reach from the ports is one where a second character is loaded while the first is still shifting. Only then do data frames run back to back, and the check value is formed across both characters before it is appended. The bench gets there by loading one character while the transmitter is disabled and then enabling it, so the first frame is data. It presents the second character at the first sample after the handover. It then compares the captured bit stream against a stream built arithmetically, for every data length, parity mode, polynomial, append setting and sync width. Breaks are applied while a character sits in the buffer, to show that the character is discarded.

// File: rtl/bsync_pkg.sv
package bsync_pkg;
  localparam int DATA_W = 8;
  localparam int SYNC_W = 8;
  localparam int CRC_W  = 16;
  localparam logic [CRC_W-1:0] POLY_A = 16'h8005;
  localparam logic [CRC_W-1:0] POLY_B = 16'h1021;

  typedef enum logic [1:0] {
    FR_DATA,
    FR_CHECK,
    FR_SYNC
  } frame_e;

  function automatic logic [CRC_W-1:0] crc_bit(input logic [CRC_W-1:0] c,
                                              input logic b,
                                              input logic sel);
    logic fb;
    fb = b ^ c[CRC_W-1];
    crc_bit = {c[CRC_W-2:0], 1'b0} ^ (fb ? (sel ? POLY_B : POLY_A) : '0);
  endfunction
endpackage

// File: rtl/bsync_txbuf.sv
module bsync_txbuf #(
  parameter int DW = bsync_pkg::DATA_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          brk,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data,
  output logic          in_ready,
  input  logic          take,
  input  logic          tie,
  output logic          full,
  output logic [DW-1:0] dout,
  output logic          irq
);
  logic pend;
  logic accept;

  assign in_ready = !full && !brk;
  assign accept   = in_valid && in_ready;
  assign irq      = tie && pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full <= 1'b0;
      dout <= '0;
      pend <= 1'b0;
    end else if (brk) begin
      full <= 1'b0;
      pend <= 1'b0;
    end else begin
      if (take) begin
        full <= 1'b0;
        pend <= 1'b1;
      end else if (accept) begin
        full <= 1'b1;
        dout <= in_data;
        pend <= 1'b0;
      end
    end
  end

  assert_accept_fills_R2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> full);
  assert_take_empties_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !brk) |=> (!full && pend));
  assert_brk_discard_R9: assert property (@(posedge clk) disable iff (!rst_n)
    brk |=> !full);
endmodule

// File: rtl/bsync_crc.sv
module bsync_crc #(
  parameter int DW = bsync_pkg::DATA_W,
  parameter int CW = bsync_pkg::CRC_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          upd,
  input  logic [DW-1:0] data,
  input  logic [3:0]    nbits,
  input  logic          sel,
  output logic [CW-1:0] crc
);
  logic [CW-1:0] nxt;

  always_comb begin
    nxt = crc;
    for (int i = 0; i < DW; i++) begin
      if (i < int'(nbits)) nxt = bsync_pkg::crc_bit(nxt, data[i], sel);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   crc <= '0;
    else if (clr) crc <= '0;
    else if (upd) crc <= nxt;
  end

  assert_crc_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (crc == '0));
endmodule

// File: rtl/bsync_framer.sv
module bsync_framer #(
  parameter int DW = bsync_pkg::DATA_W,
  parameter int SW = bsync_pkg::SYNC_W,
  parameter int CW = bsync_pkg::CRC_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          brk,
  input  logic          active,
  input  logic          bit_en,
  input  logic          buf_full,
  input  logic [DW-1:0] buf_data,
  input  logic [1:0]    len_sel,
  input  logic          par_en,
  input  logic          par_odd,
  input  logic [CW-1:0] crc_val,
  input  logic          crc_append,
  input  logic          sync16,
  input  logic [SW-1:0] sync_lo,
  input  logic [SW-1:0] sync_hi,
  output logic          take,
  output logic          crc_clr,
  output logic [3:0]    nbits,
  output logic          txd_q
);
  import bsync_pkg::*;

  localparam int FW0 = (2 * SW > CW) ? 2 * SW : CW;
  localparam int FW  = (DW + 1 > FW0) ? DW + 1 : FW0;
  localparam int NW  = $clog2(FW + 1);

  logic [FW-1:0] sr, frm;
  logic [NW-1:0] rem, flen;
  logic          pend;
  logic          boundary, send_chk;
  logic          par;
  frame_e        kind;
  int            n;

  assign n        = DW - 3 + int'(len_sel);
  assign nbits    = 4'(n);
  assign boundary = active && !brk && bit_en && (rem == '0);
  assign take     = boundary && buf_full;
  assign send_chk = boundary && !buf_full && pend;
  assign crc_clr  = send_chk || !active || brk;

  always_comb begin
    if (buf_full)  kind = FR_DATA;
    else if (pend) kind = FR_CHECK;
    else           kind = FR_SYNC;
  end

  always_comb begin
    frm = '0;
    flen = '0;
    par = par_odd;
    case (kind)
      FR_DATA: begin
        for (int i = 0; i < DW; i++) begin
          if (i < n) begin
            frm[i] = buf_data[i];
            par    = par ^ buf_data[i];
          end
        end
        if (par_en) frm[n] = par;
        flen = NW'(n) + NW'(par_en);
      end
      FR_CHECK: begin
        for (int i = 0; i < CW; i++) frm[i] = crc_val[CW-1-i];
        flen = NW'(CW);
      end
      default: begin
        frm[SW-1:0] = sync_lo;
        if (sync16) begin
          frm[2*SW-1:SW] = sync_hi;
          flen = NW'(2 * SW);
        end else begin
          flen = NW'(SW);
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr    <= '0;
      rem   <= '0;
      txd_q <= 1'b1;
      pend  <= 1'b0;
    end else if (brk || !active) begin
      rem   <= '0;
      txd_q <= 1'b1;
      pend  <= 1'b0;
    end else if (bit_en) begin
      if (rem == '0) begin
        txd_q <= frm[0];
        sr    <= frm >> 1;
        rem   <= flen - NW'(1);
        if (take)          pend <= crc_append;
        else if (send_chk) pend <= 1'b0;
      end else begin
        txd_q <= sr[0];
        sr    <= sr >> 1;
        rem   <= rem - NW'(1);
      end
    end
  end

  assert_idle_mark_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (brk || !active) |=> (txd_q && rem == '0));
  assert_hold_no_tick_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !brk && !bit_en) |=> $stable(txd_q));
  assert_break_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    brk |=> !pend);

  always_comb begin
    if (rst_n) assert_rem_bound_R3: assert (int'(rem) < FW);
  end
endmodule

// File: rtl/bsync_tx.sv
module bsync_tx (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tx_en,
  input  logic       cts_en,
  input  logic       brk,
  input  logic       tx_int_en,
  input  logic [1:0] len_sel,
  input  logic       par_en,
  input  logic       par_odd,
  input  logic       crc_sel,
  input  logic       crc_append,
  input  logic       sync16,
  input  logic [7:0] sync_lo,
  input  logic [7:0] sync_hi,
  input  logic       bit_en,
  input  logic       in_valid,
  input  logic [7:0] in_data,
  output logic       in_ready,
  output logic       txd,
  output logic       buf_empty,
  output logic       irq
);
  import bsync_pkg::*;

  logic              active, full, take, crc_clr, txd_q;
  logic [DATA_W-1:0] buf_data;
  logic [CRC_W-1:0]  crc_val;
  logic [3:0]        nbits;

  assign active    = tx_en && cts_en;
  assign buf_empty = !full;
  assign txd       = brk ? 1'b0 : txd_q;

  bsync_txbuf #(.DW(DATA_W)) u_buf (
    .clk(clk), .rst_n(rst_n), .brk(brk), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .take(take), .tie(tx_int_en), .full(full),
    .dout(buf_data), .irq(irq)
  );

  bsync_crc #(.DW(DATA_W), .CW(CRC_W)) u_crc (
    .clk(clk), .rst_n(rst_n), .clr(crc_clr), .upd(take), .data(buf_data),
    .nbits(nbits), .sel(crc_sel), .crc(crc_val)
  );

  bsync_framer #(.DW(DATA_W), .SW(SYNC_W), .CW(CRC_W)) u_frm (
    .clk(clk), .rst_n(rst_n), .brk(brk), .active(active), .bit_en(bit_en),
    .buf_full(full), .buf_data(buf_data), .len_sel(len_sel), .par_en(par_en),
    .par_odd(par_odd), .crc_val(crc_val), .crc_append(crc_append),
    .sync16(sync16), .sync_lo(sync_lo), .sync_hi(sync_hi), .take(take),
    .crc_clr(crc_clr), .nbits(nbits), .txd_q(txd_q)
  );

  assert_brk_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (brk && $past(brk)) |-> !txd && !in_ready);
endmodule

// File: tb/bsync_tx_bench.sv
module bsync_tx_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx_en = 1'b0, cts_en = 1'b1, brk = 1'b0, tx_int_en = 1'b1;
  logic [1:0] len_sel = 2'd3;
  logic par_en = 1'b0, par_odd = 1'b0, crc_sel = 1'b0, crc_append = 1'b0, sync16 = 1'b0;
  logic [7:0] sync_lo = 8'h16, sync_hi = 8'h3C;
  logic bit_en = 1'b1, in_valid = 1'b0;
  logic [7:0] in_data = '0;
  logic in_ready, txd, buf_empty, irq;

  int checks = 0, fails = 0, cyc = 0;
  logic exp_bits [0:79];
  logic got_bits [0:79];
  int ne;

  always #2 clk = ~clk;

  bsync_tx u_bsync_tx (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .cts_en(cts_en), .brk(brk),
    .tx_int_en(tx_int_en), .len_sel(len_sel), .par_en(par_en), .par_odd(par_odd),
    .crc_sel(crc_sel), .crc_append(crc_append), .sync16(sync16),
    .sync_lo(sync_lo), .sync_hi(sync_hi), .bit_en(bit_en), .in_valid(in_valid),
    .in_data(in_data), .in_ready(in_ready), .txd(txd), .buf_empty(buf_empty), .irq(irq)
  );

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [15:0] ref_crc(input logic [15:0] c, input logic b, input logic s);
    logic [15:0] p;
    p = s ? 16'h1021 : 16'h8005;
    return (c[15] ^ b) ? ((c << 1) ^ p) : (c << 1);
  endfunction

  task automatic push(input logic b);
    exp_bits[ne] = b;
    ne++;
  endtask

  task automatic add_char(input logic [7:0] d, inout logic [15:0] c);
    int n;
    logic p;
    n = 5 + int'(len_sel);
    p = par_odd;
    for (int i = 0; i < n; i++) begin
      push(d[i]);
      p = p ^ d[i];
      c = ref_crc(c, d[i], crc_sel);
    end
    if (par_en) push(p);
  endtask

  task automatic add_sync();
    for (int i = 0; i < 8; i++) push(sync_lo[i]);
    if (sync16) for (int i = 0; i < 8; i++) push(sync_hi[i]);
  endtask

  task automatic load_idle(input logic [7:0] d);
    @(negedge clk);
    in_valid = 1'b1;
    in_data = d;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // Sweep one configuration: two back-to-back characters, optional check, syncs.
  task automatic run_cfg(input int idx);
    logic [7:0] d1, d2;
    logic [15:0] c;
    logic rdy_seen;
    int bad;
    d1 = 8'(idx * 37 + 11);
    d2 = 8'(idx * 91 + 200);
    @(negedge clk);
    tx_en = 1'b0;
    len_sel = 2'(idx % 4);
    par_en = ((idx / 4) % 3) != 0;
    par_odd = ((idx / 4) % 3) == 2;
    crc_sel = 1'((idx / 12) % 2);
    crc_append = 1'((idx / 24) % 2);
    sync16 = 1'((idx / 48) % 2);
    sync_lo = 8'h96 ^ 8'(idx);
    sync_hi = 8'h3C + 8'(idx);
    load_idle(d1);
    ne = 0;
    c = '0;
    add_char(d1, c);
    add_char(d2, c);
    if (crc_append) for (int i = 15; i >= 0; i--) push(c[i]);
    add_sync();
    add_sync();
    tx_en = 1'b1;
    rdy_seen = 1'b0;
    bad = -1;
    for (int i = 0; i < ne; i++) begin
      @(negedge clk);
      if (in_valid && rdy_seen) in_valid = 1'b0;
      got_bits[i] = txd;
      if (i == 0) begin
        chk(buf_empty && irq, "R10 take empties buffer, irq", int'({buf_empty, irq}), 3);
        in_valid = 1'b1;
        in_data = d2;
      end
      rdy_seen = in_ready;
      if (got_bits[i] !== exp_bits[i] && bad < 0) bad = i;
    end
    if (bad >= 0)
      $display("FAIL R3 R4 R5 R6 R7 cfg %0d bit %0d actual=%0d expected=%0d",
               idx, bad, got_bits[bad], exp_bits[bad]);
    checks++;
    if (bad >= 0) fails++;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(txd && in_ready && buf_empty && !irq, "R1 reset state",
        int'({txd, in_ready, buf_empty, irq}), 14);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: disabled line idles high, buffer not consumed
    load_idle(8'hA5);
    chk(!buf_empty && !in_ready, "R2 buffer full after accept", int'({buf_empty, in_ready}), 0);
    repeat (5) @(negedge clk);
    chk(txd && !buf_empty, "R1 disabled holds mark and buffer", int'({txd, buf_empty}), 2);
    // R1: clear-to-send low also pauses
    tx_en = 1'b1;
    cts_en = 1'b0;
    repeat (4) @(negedge clk);
    chk(txd && !buf_empty, "R1 cts low pauses", int'({txd, buf_empty}), 2);
    // R11: no bit clock, no advance
    bit_en = 1'b0;
    cts_en = 1'b1;
    repeat (4) @(negedge clk);
    chk(txd && !buf_empty, "R11 no bit_en holds line", int'({txd, buf_empty}), 2);
    bit_en = 1'b1;
    @(negedge clk);
    chk(txd == 1'b1 && buf_empty, "R11 first bit of 8'hA5", int'(txd), 1);
    @(negedge clk);
    chk(txd == 1'b0, "R3 LSB-first second bit", int'(txd), 0);
    bit_en = 1'b0;
    repeat (3) @(negedge clk);
    chk(txd == 1'b0, "R11 hold between ticks", int'(txd), 0);
    bit_en = 1'b1;
    tx_int_en = 1'b0;
    #1;
    chk(!irq, "R10 irq masked", int'(irq), 0);
    tx_int_en = 1'b1;
    // R8/R9: break while disabled with a character buffered
    tx_en = 1'b0;
    load_idle(8'h5A);
    brk = 1'b1;
    #1;
    chk(txd == 1'b0, "R8 break immediate low", int'(txd), 0);
    @(negedge clk);
    chk(buf_empty && !in_ready, "R9 break discards buffer", int'({buf_empty, in_ready}), 2);
    brk = 1'b0;
    #1;
    chk(txd == 1'b1, "R8 break release", int'(txd), 1);
    sync16 = 1'b0;
    sync_lo = 8'hC3;
    tx_en = 1'b1;
    begin
      logic [7:0] g;
      for (int i = 0; i < 8; i++) begin
        @(negedge clk);
        g[i] = txd;
      end
      chk(g == 8'hC3, "R9 R5 sync after break", int'(g), 8'hC3);
    end
    // R8: break during active transmission
    brk = 1'b1;
    #1;
    chk(txd == 1'b0, "R8 break while active", int'(txd), 0);
    @(negedge clk);
    brk = 1'b0;
    tx_en = 1'b0;
    @(negedge clk);
    for (int idx = 0; idx < 96; idx++) run_cfg(idx);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=0", cyc);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule